// File: doc/BRIEF.md
# Keyed Reset Controller

This block generates the processor, peripheral and external reset pulses of a chip under software control and watches the external reset line for resets raised from outside. Software reaches it through a small register bus with a control register, a mode register and a status register. A write to the control or mode register counts only when the top byte of the write data carries the unlock key. Without the key the write does nothing, so a stray store cannot reset the chip.

The external line is open-drain. The block only ever pulls it low, for a power-of-two number of slow-clock periods chosen by a length field. The slow clock reaches the block as a one-cycle strobe in the system clock domain. The line level is synchronised and then watched for falling edges that the block did not cause itself. Such an edge sets a sticky flag, which a read of the status register clears. The flag can raise an interrupt, or it can start a processor reset.

Top module: `key_reset_ctrl`

## Requirements
- R1: A write to the control register (offset 0x0) or the mode register (offset 0x4) changes nothing unless `bus_wdata[31:24]` is 0xA5.
- R2: Register reads return their data in the cycle after `bus_rd`. The mode register reads back bit 0 (user-reset enable), bit 4 (interrupt enable) and bits [11:8] (length field), with all other bits 0. The control register reads as 0.
- R3: A keyed control write with bit 3 set pulls the external line low (`pin_drive_low` = 1) for exactly 2^(L+1) slow-clock strobes, where L is the mode length field.
- R4: A keyed control write with bit 0 set asserts `proc_rst`, and one with bit 2 set asserts `periph_rst`, each for exactly 3 slow-clock strobes.
- R5: Status bit 17 (busy) is 1 while any reset pulse is running and 0 once all have ended.
- R6: A control write that arrives while busy is 1 is ignored entirely.
- R7: Status bit 16 reports the line level after a two-flop synchroniser.
- R8: Status bit 0 sets on each falling edge of the synchronised line, except an edge caused by the block's own drive. It stays set until a status read (offset 0x8), and that read still returns 1 and clears the bit.
- R9: `irq` equals status bit 0 ANDed with mode bit 4.
- R10: With mode bit 0 set, a detected falling edge of the line starts a 3-strobe `proc_rst` pulse. With mode bit 0 clear, such an edge does not touch `proc_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, key in [31:24] |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | 1 | Sampled level of the external reset line |
| pin_drive_low | output | 1 | Pull the external line low when 1 |
| proc_rst | output | 1 | Processor reset |
| periph_rst | output | 1 | Peripheral reset |
| irq | output | 1 | User-reset interrupt |

## Verification
The bench runs the external pulse at three length settings. A design that gets the power-of-two length wrong, or is off by one strobe, produces a strobe count that does not match the expected value. It reads the status register during the block's own drive and after it. A design that fails to mask its own edges shows a spurious user-reset flag there. It sends unkeyed writes and a keyed command while busy; a design that ignores the key or the busy gate produces a pulse or a mode change that should never appear. It also reads the status register twice after an external edge. A design whose read does not clear the flag, or that clears it before returning it, returns the wrong pair of values.

// File: rtl/key_rst_pkg.sv
// Shared constants for the keyed reset controller: register offsets,
// bit positions and the unlock key. Assumes a 4-bit byte-offset bus.
package key_rst_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 4;

    localparam logic [7:0]        UNLOCK_KEY = 8'hA5;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_MODE   = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 4'h8;

    localparam int CTRL_PROC_BIT   = 0;
    localparam int CTRL_PERIPH_BIT = 2;
    localparam int CTRL_EXT_BIT    = 3;
    localparam int MODE_UEN_BIT    = 0;
    localparam int MODE_IEN_BIT    = 4;
    localparam int MODE_LEN_LSB    = 8;
    localparam int STAT_FLAG_BIT   = 0;
    localparam int STAT_LVL_BIT    = 16;
    localparam int STAT_BUSY_BIT   = 17;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             irq_en;
        logic             usr_en;
    } mode_t;
endpackage

// File: rtl/krc_regs.sv
// Register decode for the keyed reset controller. Holds the mode register,
// turns keyed control writes into one-cycle command strobes (dropped while
// busy), flags status reads and registers the read data.
// Assumes bus strobes are single-cycle and synchronous to clk.
module krc_regs
    import key_rst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    input  logic              busy,
    input  logic              flag,
    input  logic              pin_lvl,
    output logic [DATA_W-1:0] rdata,
    output mode_t             mode,
    output logic              cmd_proc,
    output logic              cmd_periph,
    output logic              cmd_ext,
    output logic              stat_rd
);
    logic        key_ok;
    logic        ctrl_go;
    logic        mode_go;
    mode_t       mode_q;
    logic [DATA_W-1:0] rd_val;
    logic        unused_wdata;

    assign key_ok  = (wdata[DATA_W-1:DATA_W-8] == UNLOCK_KEY);
    assign ctrl_go = wr && (addr == OFS_CTRL) && key_ok && !busy;
    assign mode_go = wr && (addr == OFS_MODE) && key_ok;
    assign stat_rd = rd && (addr == OFS_STAT);

    assign cmd_proc   = ctrl_go && wdata[CTRL_PROC_BIT];
    assign cmd_periph = ctrl_go && wdata[CTRL_PERIPH_BIT];
    assign cmd_ext    = ctrl_go && wdata[CTRL_EXT_BIT];
    assign mode       = mode_q;

    assign unused_wdata = ^{wdata[23:12], wdata[7:5], wdata[3:1]};

    // Mode register: updated only by a keyed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_go) begin
            mode_q.usr_en <= wdata[MODE_UEN_BIT];
            mode_q.irq_en <= wdata[MODE_IEN_BIT];
            mode_q.len    <= wdata[MODE_LEN_LSB +: LEN_W];
        end
    end

    // Read mux: assemble the addressed register image.
    always_comb begin
        rd_val = '0;
        case (addr)
            OFS_MODE: begin
                rd_val[MODE_UEN_BIT]               = mode_q.usr_en;
                rd_val[MODE_IEN_BIT]               = mode_q.irq_en;
                rd_val[MODE_LEN_LSB +: LEN_W]      = mode_q.len;
            end
            OFS_STAT: begin
                rd_val[STAT_FLAG_BIT] = flag;
                rd_val[STAT_LVL_BIT]  = pin_lvl;
                rd_val[STAT_BUSY_BIT] = busy;
            end
            default: rd_val = '0;
        endcase
    end

    // Read data register: captured on a read strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_val;
    end

    // R1: the mode register keeps its value across any unkeyed or non-mode write
    p_mode_keyed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (addr == OFS_MODE) && key_ok) |=> $stable(mode_q));
endmodule

// File: rtl/krc_pulse.sv
// Down-counting pulse timer paced by the slow-clock strobe. A start while idle
// loads the length; the output stays high until that many strobes have been
// seen. Assumes load is non-zero whenever start is raised.
module krc_pulse #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             active
);
    logic [CNT_W-1:0] cnt_q;

    assign active = |cnt_q;

    // Counter: load on start when idle, count strobes down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (start && !active)     cnt_q <= load;
        else if (tick && active)       cnt_q <= cnt_q - 1'b1;
    end

    // R3: a start on an idle timer loads the requested length
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cnt_q == '0) |=> (cnt_q == $past(load)));

    // R3: a running pulse only moves on a slow-clock strobe
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/krc_pin_mon.sv
// External line monitor: two-flop synchroniser, falling-edge detect masked
// while (and shortly after) the block drives the line itself, and the sticky
// user-reset flag cleared by a status read. Assumes the line idles high.
module krc_pin_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic own_drive,
    input  logic clr,
    output logic lvl,
    output logic fall_seen,
    output logic flag
);
    localparam int GUARD = SYNC_STAGES + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [GUARD-1:0]       drv_hist;
    logic                   masked;

    assign lvl       = sync_q[SYNC_STAGES-1];
    assign masked    = own_drive || (|drv_hist);
    assign fall_seen = prev_q && !lvl && !masked;

    // Synchroniser chain plus one stage of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
            prev_q <= lvl;
        end
    end

    // Drive history: covers the synchroniser latency after own drive ends.
    always_ff @(posedge clk) begin
        if (!rst_n) drv_hist <= '0;
        else        drv_hist <= {drv_hist[GUARD-2:0], own_drive};
    end

    // Sticky flag: a new edge wins over a clearing read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (fall_seen) flag <= 1'b1;
        else if (clr)       flag <= 1'b0;
    end

    // R8: a foreign falling edge sets the flag
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_seen |=> flag);

    // R8: a status read with no new edge clears the flag
    p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fall_seen) |=> !flag);
endmodule

// File: rtl/key_reset_ctrl.sv
// Keyed reset controller top: register decode, three pulse timers (processor,
// peripheral, external line) and the line monitor. Assumes slow_tick is a
// one-cycle strobe in the clk domain, with at least one idle cycle between strobes.
module key_reset_ctrl
    import key_rst_pkg::*;
#(
    parameter int SYS_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pin_in,
    output logic              pin_drive_low,
    output logic              proc_rst,
    output logic              periph_rst,
    output logic              irq
);
    localparam int CNT_W = (1 << LEN_W) + 1;

    mode_t            mode;
    logic             cmd_proc, cmd_periph, cmd_ext, stat_rd;
    logic             busy, flag, pin_lvl, fall_seen, usr_trig;
    logic             proc_act, periph_act, ext_act;
    logic [CNT_W-1:0] ext_load;
    logic [CNT_W-1:0] sys_load;

    assign busy     = proc_act || periph_act || ext_act;
    assign usr_trig = fall_seen && mode.usr_en && !proc_act;
    assign ext_load = {{(CNT_W-1){1'b0}}, 1'b1} << ({28'd0, mode.len} + 32'd1);
    assign sys_load = CNT_W'(SYS_TICKS);

    assign pin_drive_low = ext_act;
    assign proc_rst      = proc_act;
    assign periph_rst    = periph_act;
    assign irq           = flag && mode.irq_en;

    krc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .wr         (bus_wr),
        .wdata      (bus_wdata),
        .rd         (bus_rd),
        .busy       (busy),
        .flag       (flag),
        .pin_lvl    (pin_lvl),
        .rdata      (bus_rdata),
        .mode       (mode),
        .cmd_proc   (cmd_proc),
        .cmd_periph (cmd_periph),
        .cmd_ext    (cmd_ext),
        .stat_rd    (stat_rd)
    );

    krc_pulse #(.CNT_W(CNT_W)) u_proc (
        .clk(clk), .rst_n(rst_n), .tick(slow_tick),
        .start(cmd_proc || usr_trig), .load(sys_load), .active(proc_act)
    );

    krc_pulse #(.CNT_W(CNT_W)) u_periph (
        .clk(clk), .rst_n(rst_n), .tick(slow_tick),
        .start(cmd_periph), .load(sys_load), .active(periph_act)
    );

    krc_pulse #(.CNT_W(CNT_W)) u_ext (
        .clk(clk), .rst_n(rst_n), .tick(slow_tick),
        .start(cmd_ext), .load(ext_load), .active(ext_act)
    );

    krc_pin_mon #(.SYNC_STAGES(2)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .own_drive (ext_act),
        .clr       (stat_rd),
        .lvl       (pin_lvl),
        .fall_seen (fall_seen),
        .flag      (flag)
    );

    // R6: while busy, an idle processor timer can only be started by a user reset
    p_busy_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !proc_act && !usr_trig) |=> !proc_act);

    // R10: with user reset disabled, a line edge never starts the processor timer
    p_usr_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.usr_en && !proc_act && !cmd_proc) |=> !proc_act);
endmodule

// File: tb/sim_key_reset_ctrl.sv
// Scoreboard bench: the read task queues expected register images, a monitor
// compares them one cycle later; pulse lengths are measured in slow strobes.
module sim_key_reset_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        pin_drive_low, proc_rst, periph_rst, irq;
    logic        ext_lvl = 1'b1;
    logic        pin_line;

    int checks = 0;
    int errors = 0;
    int ext_ticks = 0, proc_ticks = 0, per_ticks = 0;
    int proc_hi = 0, per_hi = 0;
    logic rd_seen = 1'b0;
    bit   done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    assign pin_line = pin_drive_low ? 1'b0 : ext_lvl;

    always #5 clk = ~clk;

    key_reset_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pin_in(pin_line),
        .pin_drive_low(pin_drive_low), .proc_rst(proc_rst),
        .periph_rst(periph_rst), .irq(irq)
    );

    // slow strobe: one cycle in four
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = ph + 1;
            slow_tick = (ph % 4 == 3);
        end
    end

    // strobe and level counters over pre-edge values
    always @(posedge clk) begin
        if (pin_drive_low && slow_tick) ext_ticks <= ext_ticks + 1;
        if (proc_rst && slow_tick)      proc_ticks <= proc_ticks + 1;
        if (periph_rst && slow_tick)    per_ticks <= per_ticks + 1;
        if (proc_rst)                   proc_hi <= proc_hi + 1;
        if (periph_rst)                 per_hi <= per_hi + 1;
        rd_seen <= bus_rd;
    end

    // monitor: compare read data against the scoreboard
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected read: actual %h expected none", "R2", bus_rdata);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s read: actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
        rd_item_t it;
        @(negedge clk);
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_low(ref logic sig);
        int guard = 0;
        while (sig && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic ext_len(input int len, input int exp_ticks);
        int base;
        wr_reg(4'h4, 32'hA5000000 | (len << 8));
        wr_reg(4'h0, 32'hA5000008);
        base = ext_ticks;
        check("R3 drive starts", int'(pin_drive_low), 1);
        wait_low(pin_drive_low);
        check($sformatf("R3 len %0d strobes", len), ext_ticks - base, exp_ticks);
        idle(4);
    endtask

    task automatic pin_pulse(input int low_cycles);
        @(negedge clk); ext_lvl = 1'b0;
        idle(low_cycles);
        ext_lvl = 1'b1;
        idle(5);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int b, h;
        idle(5);
        rst_n = 1'b1;
        idle(1);
        // reset state
        check("R3 reset drive", int'(pin_drive_low), 0);
        check("R4 reset proc", int'(proc_rst), 0);
        check("R4 reset periph", int'(periph_rst), 0);
        check("R9 reset irq", int'(irq), 0);
        rd_reg(4'h4, 32'h0, "R2 mode reset");
        rd_reg(4'h8, 32'h00010000, "R7 status reset");

        // R1 unkeyed writes ignored
        wr_reg(4'h4, 32'h5A000F11);
        rd_reg(4'h4, 32'h0, "R1 mode unkeyed");
        wr_reg(4'h0, 32'h5A00000D);
        idle(3);
        check("R1 ctrl unkeyed drive", int'(pin_drive_low), 0);
        check("R1 ctrl unkeyed proc", int'(proc_rst), 0);

        // R2 readback masking
        wr_reg(4'h4, 32'hA5FFFFFF);
        rd_reg(4'h4, 32'h00000F11, "R2 mode mask");
        rd_reg(4'h0, 32'h0, "R2 ctrl reads zero");

        // R3 pulse lengths
        ext_len(0, 2);
        ext_len(1, 4);

        // R3/R5/R8 during own drive
        wr_reg(4'h4, 32'hA5000200);
        wr_reg(4'h0, 32'hA5000008);
        b = ext_ticks;
        idle(4);
        rd_reg(4'h8, 32'h00020000, "R5 busy during drive, R8 own edge masked");
        wait_low(pin_drive_low);
        check("R3 len 2 strobes", ext_ticks - b, 8);
        idle(5);
        rd_reg(4'h8, 32'h00010000, "R5 busy cleared, R8 no flag from own drive");

        // R4 processor and peripheral pulses
        b = proc_ticks; h = per_hi;
        wr_reg(4'h0, 32'hA5000001);
        wait_low(proc_rst);
        check("R4 proc strobes", proc_ticks - b, 3);
        check("R4 periph untouched", per_hi - h, 0);
        b = per_ticks; h = proc_hi;
        wr_reg(4'h0, 32'hA5000004);
        wait_low(periph_rst);
        check("R4 periph strobes", per_ticks - b, 3);
        check("R4 proc untouched", proc_hi - h, 0);

        // R6 command while busy ignored
        wr_reg(4'h0, 32'hA5000008);
        b = ext_ticks; h = proc_hi;
        idle(2);
        wr_reg(4'h0, 32'hA5000001);
        wait_low(pin_drive_low);
        check("R6 proc not started", proc_hi - h, 0);
        check("R6 ext unaffected", ext_ticks - b, 8);
        idle(5);

        // R7/R8 foreign low level, user reset disabled (R10)
        wr_reg(4'h4, 32'hA5000000);
        h = proc_hi;
        @(negedge clk); ext_lvl = 1'b0;
        idle(6);
        rd_reg(4'h8, 32'h00000001, "R7 level low, R8 flag set");
        ext_lvl = 1'b1;
        idle(5);
        check("R10 disabled no proc", proc_hi - h, 0);
        rd_reg(4'h8, 32'h00010000, "R8 cleared by read");

        // R8 read returns then clears
        pin_pulse(3);
        rd_reg(4'h8, 32'h00010001, "R8 flag after edge");
        rd_reg(4'h8, 32'h00010000, "R8 flag cleared");

        // R9 interrupt
        wr_reg(4'h4, 32'hA5000010);
        pin_pulse(3);
        check("R9 irq on flag", int'(irq), 1);
        rd_reg(4'h8, 32'h00010001, "R9 flag seen");
        check("R9 irq drops after read", int'(irq), 0);
        wr_reg(4'h4, 32'hA5000000);
        pin_pulse(3);
        check("R9 irq masked", int'(irq), 0);
        rd_reg(4'h8, 32'h00010001, "R9 flag without irq");

        // R10 user reset starts processor pulse
        wr_reg(4'h4, 32'hA5000001);
        b = proc_ticks;
        pin_pulse(2);
        check("R10 proc asserted", int'(proc_rst), 1);
        wait_low(proc_rst);
        check("R10 proc strobes", proc_ticks - b, 3);
        rd_reg(4'h8, 32'h00010001, "R10 flag set");

        idle(2);
        check("R2 scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule